// File: doc/BRIEF.md
# Windowed Threshold Interrupt Controller

This block watches a stream of conversion results from a four-channel converter. It raises an active-low interrupt when the chosen channel leaves a programmed low/high window. A conversion-done strobe delivers all four channel values at once. A source select picks the channel that is compared. A persistence filter decides whether one excursion is enough, or whether the channel must stay out of the window for a number of prescaled time ticks.

The interrupt has four modes: off, level, alert-style and software-forced. A level interrupt stays asserted until a clear strobe arrives. An alert-style interrupt is released only by the pulse that the external alert-response logic produces once its cycle succeeds. The forced mode raises the interrupt straight after the control write and then behaves as alert-style. An optional stop-on-interrupt bit freezes the integration-enable output toward the converter while the interrupt is pending. Integration resumes only after software drops the enable, clears the interrupt and raises the enable again.

Thresholds, source and control are loaded through a small write-only register port. The pad is open drain: `irq_oe_o` high means the line is pulled low, and low means the pad floats.

Top module: `thr_irq_ctrl`

## Requirements
- R1: Register writes use `reg_addr_i` to select the target. Address 0 is control, 1 is source select (data bits 1:0), 2 is the low threshold and 3 is the high threshold. In the control byte, bit 6 is stop-on-interrupt, bits 5:4 are the mode and bits 2:0 are the persistence code; bits 7 and 3 are ignored.
- R2: After reset the control is zero, the source is channel 0, the low threshold is 0 and the high threshold is all ones. `irq_oe_o` is low, and `integ_en_o` follows `adc_en_i`.
- R3: A value is out of range only when it is strictly below the low threshold or strictly above the high threshold. A value equal to either threshold is in range.
- R4: Source select k compares channel k, taken from `ch_data_i[k*DW +: DW]`; the other channels have no effect.
- R5: Mode 00 keeps `irq_oe_o` low whatever the conversions are. Writing mode 00 over a pending interrupt releases it one cycle after the write.
- R6: With persistence code 000, every conversion strobe raises the interrupt, whatever its value.
- R7: With persistence code 001, a single out-of-range conversion raises the interrupt, and an in-range one does not. `irq_oe_o` rises in the cycle after the strobe.
- R8: With code 010, the interrupt is raised on the SHORT_TICKS-th tick. Ticks are counted only after an out-of-range conversion. Codes 011 to 111 do the same with LONG_TICKS. An in-range conversion zeroes the count, and a count fires only once until it is zeroed.
- R9: In mode 01 the interrupt stays until `clear_i` is pulsed; `alert_clr_i` has no effect.
- R10: In modes 10 and 11 the interrupt is released by `alert_clr_i`; `clear_i` has no effect.
- R11: A control write with mode 11 raises the interrupt in the next cycle with no conversion.
- R12: If a qualifying event and a clear arrive in the same cycle, the interrupt stays asserted.
- R13: With stop-on-interrupt set, `integ_en_o` is low while the interrupt is asserted. It returns only after `adc_en_i` has been low while the interrupt is clear and is then raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DW | Register write data |
| conv_done_i | input | 1 | Conversion-done strobe |
| ch_data_i | input | 4*DW | Four channel results, channel k at bits k*DW +: DW |
| tick_i | input | 1 | Prescaled persistence time tick |
| clear_i | input | 1 | Clear command for level mode |
| alert_clr_i | input | 1 | Successful alert-response pulse |
| adc_en_i | input | 1 | Integration enable from software |
| integ_en_o | output | 1 | Integration enable toward the converter |
| irq_oe_o | output | 1 | Open-drain pull-down enable (interrupt asserted) |

## Verification
The hardest situation to reach is the timed persistence filter. Ticks must meet a run of out-of-range conversions that has already started, and in-range conversions must break that run partway through. The stimulus first sends one in-range conversion to zero the count, then one out-of-range conversion, then steps ticks one at a time up to one short of the limit. It adds in-range breaks part way and finally sends the last tick. The stop-and-resume handshake is driven in both orders, so that raising the enable without a clear is shown not to restart integration.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_LEVEL = 2'b01,
    MODE_ALERT = 2'b10,
    MODE_FORCE = 2'b11
  } irq_mode_e;

  typedef struct packed {
    logic       stop;
    irq_mode_e  mode;
    logic [2:0] persist;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_LOW  = 2'd2;
  localparam logic [1:0] ADDR_HIGH = 2'd3;

  localparam logic [2:0] PERS_EVERY  = 3'd0;
  localparam logic [2:0] PERS_SINGLE = 3'd1;
  localparam logic [2:0] PERS_SHORT  = 3'd2;

endpackage

// File: rtl/thr_irq_regs.sv
module thr_irq_regs
  import thr_irq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic [1:0]    src_o,
  output logic [DW-1:0] low_o,
  output logic [DW-1:0] high_o,
  output logic          force_o
);

  ctrl_t         ctrl_q;
  logic [1:0]    src_q;
  logic [DW-1:0] low_q, high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
      low_q  <= '0;
      high_q <= '1;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          ctrl_q.stop    <= wdata_i[6];
          ctrl_q.mode    <= irq_mode_e'(wdata_i[5:4]);
          ctrl_q.persist <= wdata_i[2:0];
        end
        ADDR_SRC:  src_q  <= wdata_i[1:0];
        ADDR_LOW:  low_q  <= wdata_i;
        default:   high_q <= wdata_i;
      endcase
    end
  end

  // software-set strobe: control write selecting the forced mode
  assign force_o = we_i && (addr_i == ADDR_CTRL) && (wdata_i[5:4] == 2'b11);

  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;
  assign low_o  = low_q;
  assign high_o = high_q;

  a_r1_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL) |=>
      (ctrl_q.mode == irq_mode_e'($past(wdata_i[5:4])) && ctrl_q.stop == $past(wdata_i[6])));

  a_r1_src_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_SRC) |=> (src_q == $past(wdata_i[1:0])));

endmodule

// File: rtl/thr_irq_filter.sv
module thr_irq_filter
  import thr_irq_pkg::*;
#(
  parameter int DW          = 16,
  parameter int NCH         = 4,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [NCH*DW-1:0] ch_data_i,
  input  logic [$clog2(NCH)-1:0] src_i,
  input  logic [DW-1:0]     low_i,
  input  logic [DW-1:0]     high_i,
  input  logic [2:0]        persist_i,
  input  logic              tick_i,
  output logic              event_o
);

  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(LONG_TICKS);

  logic [DW-1:0] ch_arr [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_unpack
    assign ch_arr[k] = ch_data_i[k*DW +: DW];
  end

  logic [DW-1:0]    sel_val;
  logic             out_win, conv_in, conv_out, timed, tick_cnt, hit;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign sel_val  = ch_arr[src_i];
  assign out_win  = (sel_val < low_i) || (sel_val > high_i);
  assign conv_in  = conv_done_i && !out_win;
  assign conv_out = conv_done_i && out_win;
  assign timed    = persist_i >= PERS_SHORT;
  assign last_q   = (persist_i == PERS_SHORT) ? SHORT_LAST : LONG_LAST;
  assign tick_cnt = run_q && tick_i && !conv_in;
  assign hit      = tick_cnt && (cnt_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (conv_in) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (conv_out) run_q <= 1'b1;
      if (tick_cnt && cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    event_o = 1'b0;
    if (timed)                           event_o = hit;
    else if (persist_i == PERS_SINGLE)   event_o = conv_out;
    else if (persist_i == PERS_EVERY)    event_o = conv_done_i;
  end

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  a_r8_inrange_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_in |=> (cnt_q == '0 && !run_q));

  a_r8_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !conv_done_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/thr_irq_core.sv
module thr_irq_core
  import thr_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  irq_mode_e mode_i,
  input  logic      stop_i,
  input  logic      event_i,
  input  logic      force_i,
  input  logic      clear_i,
  input  logic      alert_clr_i,
  input  logic      adc_en_i,
  output logic      irq_o,
  output logic      integ_en_o
);

  logic irq_q, irq_d, halt_q, halt_d, clr_hit;

  assign clr_hit = (mode_i == MODE_LEVEL && clear_i) ||
                   ((mode_i == MODE_ALERT || mode_i == MODE_FORCE) && alert_clr_i);

  // set beats clear in the same cycle
  always_comb begin
    if (force_i)                irq_d = 1'b1;
    else if (mode_i == MODE_OFF) irq_d = 1'b0;
    else if (event_i)           irq_d = 1'b1;
    else if (clr_hit)           irq_d = 1'b0;
    else                        irq_d = irq_q;
  end

  always_comb begin
    if (stop_i && irq_q)         halt_d = 1'b1;
    else if (!adc_en_i && !irq_q) halt_d = 1'b0;
    else                         halt_d = halt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      halt_q <= halt_d;
    end
  end

  assign irq_o      = irq_q;
  assign integ_en_o = adc_en_i && !halt_q && !(stop_i && irq_q);

  a_r5_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !force_i) |=> !irq_q);

  a_r11_force_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> irq_q);

  a_r9_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && mode_i == MODE_LEVEL && !clear_i) |=> irq_q);

  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && mode_i != MODE_OFF) |=> irq_q);

  a_r13_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && irq_q) |=> !integ_en_o);

endmodule

// File: rtl/thr_irq_ctrl.sv
module thr_irq_ctrl
  import thr_irq_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  input  logic            conv_done_i,
  input  logic [4*DW-1:0] ch_data_i,
  input  logic            tick_i,
  input  logic            clear_i,
  input  logic            alert_clr_i,
  input  logic            adc_en_i,
  output logic            integ_en_o,
  output logic            irq_oe_o
);

  localparam int NCH = 4;

  ctrl_t         ctrl;
  logic [1:0]    src;
  logic [DW-1:0] low_thr, high_thr;
  logic          force_set, qual_event;

  thr_irq_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .src_o   (src),
    .low_o   (low_thr),
    .high_o  (high_thr),
    .force_o (force_set)
  );

  thr_irq_filter #(
    .DW(DW), .NCH(NCH), .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
  ) u_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .ch_data_i   (ch_data_i),
    .src_i       (src),
    .low_i       (low_thr),
    .high_i      (high_thr),
    .persist_i   (ctrl.persist),
    .tick_i      (tick_i),
    .event_o     (qual_event)
  );

  thr_irq_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (ctrl.mode),
    .stop_i      (ctrl.stop),
    .event_i     (qual_event),
    .force_i     (force_set),
    .clear_i     (clear_i),
    .alert_clr_i (alert_clr_i),
    .adc_en_i    (adc_en_i),
    .irq_o       (irq_oe_o),
    .integ_en_o  (integ_en_o)
  );

endmodule

// File: tb/tb_thr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_thr_irq_ctrl;

  localparam int DW = 16, SHORT = 1, LONG = 10;

  logic clk = 0, rst_n = 0;
  logic we = 0, conv = 0, tick = 0, clr = 0, alert = 0, adc_en = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] chv [4];
  logic [4*DW-1:0] ch_data;
  logic integ_en, irq_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  assign ch_data = {chv[3], chv[2], chv[1], chv[0]};

  always #5 clk = ~clk;

  thr_irq_ctrl #(.DW(DW), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .conv_done_i(conv), .ch_data_i(ch_data), .tick_i(tick), .clear_i(clr),
    .alert_clr_i(alert), .adc_en_i(adc_en), .integ_en_o(integ_en), .irq_oe_o(irq_oe)
  );

  // reference model
  int m_mode, m_stop, m_pers, m_src, m_lo, m_hi, m_cnt;
  bit m_irq, m_halt, m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_stop = 0; m_pers = 0; m_src = 0; m_lo = 0; m_hi = 65535;
      m_cnt = 0; m_irq = 0; m_halt = 0; m_run = 0;
    end else begin
      int v, tgt;
      bit oow, ev, tk, frc, clrh, nirq, nhalt;
      v = int'(chv[m_src]);
      oow = (v < m_lo) || (v > m_hi);
      ev = 0;
      if (conv && m_pers == 0) ev = 1;
      if (conv && m_pers == 1 && oow) ev = 1;
      tgt = (m_pers == 2) ? SHORT : LONG;
      tk = m_run && tick && !(conv && !oow);
      if (m_pers >= 2 && tk && m_cnt == tgt - 1) ev = 1;
      if (conv && !oow) begin m_run = 0; m_cnt = 0; end
      else begin
        if (conv) m_run = 1;
        if (tk && m_cnt < LONG) m_cnt++;
      end
      frc = we && addr == 0 && wdata[5:4] == 2'b11;
      clrh = (m_mode == 1 && clr) || (m_mode >= 2 && alert);
      if (frc) nirq = 1;
      else if (m_mode == 0) nirq = 0;
      else if (ev) nirq = 1;
      else if (clrh) nirq = 0;
      else nirq = m_irq;
      if (m_stop == 1 && m_irq) nhalt = 1;
      else if (!adc_en && !m_irq) nhalt = 0;
      else nhalt = m_halt;
      m_irq = nirq; m_halt = nhalt;
      if (we) begin
        case (addr)
          2'd0: begin m_stop = int'(wdata[6]); m_mode = int'(wdata[5:4]); m_pers = int'(wdata[2:0]); end
          2'd1: m_src = int'(wdata[1:0]);
          2'd2: m_lo = int'(wdata);
          default: m_hi = int'(wdata);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_en;
      exp_en = adc_en && !m_halt && !(m_stop == 1 && m_irq);
      checks++;
      if (irq_oe !== m_irq || integ_en !== exp_en) begin
        failures++;
        $display("FAIL model R7 R9 R13: irq=%0b exp=%0b integ=%0b exp=%0b at %0t",
                 irq_oe, m_irq, integ_en, exp_en, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    we = 1; addr = 2'(a); wdata = DW'(d);
    step();
    we = 0;
  endtask

  task automatic cv(input int c0, input int c1, input int c2, input int c3, input bit with_clr);
    chv[0] = DW'(c0); chv[1] = DW'(c1); chv[2] = DW'(c2); chv[3] = DW'(c3);
    conv = 1; clr = with_clr;
    step();
    conv = 0; clr = 0;
  endtask

  task automatic pclr();   clr = 1;   step(); clr = 0;   endtask
  task automatic palert(); alert = 1; step(); alert = 0; endtask
  task automatic ptick();  tick = 1;  step(); tick = 0;  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) chv[i] = '0;
    adc_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R2 irq after reset", irq_oe, 0);
    chk("R2 integ follows enable", integ_en, 1);

    // R5 mode off ignores conversions
    cv(5, 0, 0, 0, 0);
    chk("R5 off no irq", irq_oe, 0);

    // R6 code 000, level mode, in-range value still fires
    wr(0, 'h10);
    cv(7, 0, 0, 0, 0);
    chk("R6 every conversion", irq_oe, 1);
    pclr();
    chk("R9 clear releases level", irq_oe, 0);

    // R3 strict window, R7 single
    wr(0, 'h11); wr(2, 100); wr(3, 200);
    cv(100, 0, 0, 0, 0); chk("R3 equal low in range", irq_oe, 0);
    cv(200, 0, 0, 0, 0); chk("R3 equal high in range", irq_oe, 0);
    cv(150, 0, 0, 0, 0); chk("R7 in-range no irq", irq_oe, 0);
    cv(99, 0, 0, 0, 0);  chk("R7 below low fires", irq_oe, 1);
    pclr();
    cv(201, 0, 0, 0, 0); chk("R3 above high fires", irq_oe, 1);
    pclr();

    // R4 source select
    wr(1, 2);
    cv(50, 500, 150, 999, 0); chk("R4 other channels ignored", irq_oe, 0);
    cv(150, 150, 250, 150, 0); chk("R4 channel 2 compared", irq_oe, 1);

    // R9 alert pulse ignored in level mode
    palert(); chk("R9 alert ignored", irq_oe, 1);
    pclr();   chk("R9 clear", irq_oe, 0);

    // R12 event and clear together
    cv(0, 0, 300, 0, 1); chk("R12 set wins", irq_oe, 1);
    pclr();

    // R10 alert mode
    wr(0, 'h21);
    cv(0, 0, 20, 0, 0); chk("R10 alert mode fires", irq_oe, 1);
    pclr();   chk("R10 clear ignored", irq_oe, 1);
    palert(); chk("R10 alert releases", irq_oe, 0);

    // R8 short window
    wr(0, 'h12);
    cv(0, 0, 150, 0, 0);
    cv(0, 0, 250, 0, 0); chk("R8 no immediate fire", irq_oe, 0);
    ptick();             chk("R8 short window fires", irq_oe, 1);
    pclr();
    ptick();             chk("R8 fires once", irq_oe, 0);
    cv(0, 0, 150, 0, 0);
    ptick();             chk("R8 no count when in range", irq_oe, 0);
    cv(0, 0, 250, 0, 0);
    ptick();             chk("R8 rearmed", irq_oe, 1);
    pclr();

    // R8 long window
    wr(0, 'h13);
    cv(0, 0, 150, 0, 0);
    cv(0, 0, 250, 0, 0);
    for (int i = 0; i < LONG - 1; i++) ptick();
    chk("R8 long not yet", irq_oe, 0);
    cv(0, 0, 10, 0, 0);
    chk("R8 run continues", irq_oe, 0);
    ptick();
    chk("R8 long fires", irq_oe, 1);
    pclr();
    cv(0, 0, 150, 0, 0);
    cv(0, 0, 250, 0, 0);
    for (int i = 0; i < 5; i++) ptick();
    cv(0, 0, 150, 0, 0);
    cv(0, 0, 250, 0, 0);
    for (int i = 0; i < 5; i++) ptick();
    chk("R8 in-range break resets", irq_oe, 0);
    for (int i = 0; i < 5; i++) ptick();
    chk("R8 long after break", irq_oe, 1);
    pclr();

    // R8 code 111 behaves as long window
    wr(0, 'h17);
    cv(0, 0, 150, 0, 0);
    cv(0, 0, 250, 0, 0);
    for (int i = 0; i < LONG - 1; i++) ptick();
    chk("R8 code 111 not yet", irq_oe, 0);
    ptick();
    chk("R8 code 111 fires", irq_oe, 1);
    pclr();

    // R11 forced
    wr(0, 'h30);
    chk("R11 forced set", irq_oe, 1);
    palert();
    chk("R11 then alert releases", irq_oe, 0);

    // R5 writing off releases pending
    wr(0, 'h10);
    cv(0, 0, 0, 0, 0);
    chk("R6 pending before off", irq_oe, 1);
    wr(0, 'h00);
    chk("R5 still set in write cycle", irq_oe, 1);
    step();
    chk("R5 released after write", irq_oe, 0);

    // R13 stop on interrupt
    wr(0, 'h51);
    cv(0, 0, 250, 0, 0);
    chk("R13 irq", irq_oe, 1);
    chk("R13 integ frozen", integ_en, 0);
    adc_en = 0; step(); adc_en = 1; step();
    chk("R13 no resume without clear", integ_en, 0);
    pclr();
    chk("R13 no resume before toggle", integ_en, 0);
    adc_en = 0; step();
    adc_en = 1; step();
    chk("R13 resumes after toggle", integ_en, 1);

    repeat (3) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule